// File: doc/BRIEF.md
# Dual-Channel Output Mode Gate

This block sits between the stored output codes of a two-channel converter and its analog back end. It holds the volatile code for each channel and a small mode register. From these it derives three things for each channel: the code actually presented to the converter, a flag that ties the output to the low reference, and a flag that floats the output. A channel in a forced mode keeps its stored code unchanged, so the last written value returns as soon as the mode is released.

Three sources can silence the outputs. The first is the per-channel bits of the mode register. The second is an active-low pin that mutes both channels at once, with no clock involved; its release is resynchronised through two flops. The third is a power-up hold input, driven by the initialisation sequencer, that mutes both channels while it is high. Floating a channel takes priority over tying it low. A code of 0x00 corresponds to the low reference, and each step is 1/256 of the reference span.

Top module: `outmode_ctrl`

## Requirements
- R1: While `rst_n` is low, the mode register and both codes read 0, `out_code` is 0, `out_hiz` is 0 and `out_low` is 2'b11. The mute resynchroniser also starts in its muted state, so `out_low` stays 2'b11 after the first clock edge following reset release and clears after the second.
- R2: A clock edge with `code_we[i]` high stores `code_wdata` as the code of channel i. That value appears on `code_rdata` and, when no mode is active, on `out_code` slice i. Both enables high writes both channels.
- R3: A clock edge with `ctl_we` high stores `ctl_wdata[3:0]` in the mode register. `ctl_rdata` returns those four bits, and bits [7:4] always read 0 whatever was written to them.
- R4: Mode bit 2 (channel 0) or bit 3 (channel 1) mutes the channel. That channel's `out_low` is 1 and its `out_code` is 0x00, while its stored code on `code_rdata` is unchanged.
- R5: Mode bit 0 (channel 0) or bit 1 (channel 1) powers the channel down. That channel's `out_hiz` is 1, its `out_low` is 0 and its `out_code` is 0x00.
- R6: When the power-down bit and the mute bit of a channel are both set, the channel reports only power-down (`out_hiz`=1, `out_low`=0).
- R7: While `mute_n` is low, every channel that is not powered down has `out_low`=1 and `out_code`=0x00. This takes effect without any clock edge and overrides the mode register.
- R8: After `mute_n` returns high, the mute stays in force through the first clock edge and ends after the second.
- R9: While `pwrup_hold` is high, every channel that is not powered down is muted, as in R7.
- R10: A code written while its channel is muted or powered down is stored at once. It drives `out_code` as soon as the mode is left.
- R11: A mode register write leaves both codes unchanged, and a code write leaves the mode register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_n | input | 1 | Asynchronous active-low mute for all channels |
| pwrup_hold | input | 1 | Power-up hold; mutes all channels while high |
| ctl_we | input | 1 | Mode register write enable |
| ctl_wdata | input | 8 | Mode register write data (bits [3:0] used) |
| code_we | input | 2 | Per-channel code write enable |
| code_wdata | input | 8 | Code write data |
| ctl_rdata | output | 8 | Mode register readback |
| code_rdata | output | 16 | Stored codes, channel 0 in [7:0] |
| out_code | output | 16 | Effective codes to the converters, channel 0 in [7:0] |
| out_low | output | 2 | Per-channel tie-to-low-reference flag |
| out_hiz | output | 2 | Per-channel high-impedance flag |

## Verification
The hardest situation to reach is the tail of the pin mute. Once `mute_n` has risen, the output stays silenced for exactly one more clock edge, and that state cannot be seen in any register readback. The stimulus drops `mute_n` between clock edges and checks that the mute acts with no edge at all. It then raises the pin at a falling edge and samples `out_low` after each of the next two rising edges. The same edge counting is applied right after reset release, where the resynchroniser starts muted. Codes written while a channel is muted or floated are read back through `code_rdata` before the mode is cleared.

// File: rtl/outmode_pkg.sv
package outmode_pkg;
    localparam int unsigned CODE_W_DEF = 8;
    localparam int unsigned NCH_DEF    = 2;
    localparam int unsigned CTL_W_DEF  = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef enum logic [1:0] {
        MODE_DRIVE = 2'd0,
        MODE_LOW   = 2'd1,
        MODE_HIZ   = 2'd2
    } chan_mode_e;
endpackage

// File: rtl/outmode_mute_sync.sv
module outmode_mute_sync
    import outmode_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mute_n,
    output logic hold_o
);
    logic [SYNC_DEPTH-1:0] stage_q;

    // Set asynchronously by reset or by the pin; drained by the clock.
    always_ff @(posedge clk or negedge rst_n or negedge mute_n) begin
        if (!rst_n || !mute_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[SYNC_DEPTH-2:0], 1'b0};
        end
    end

    assign hold_o = stage_q[SYNC_DEPTH-1];
endmodule

// File: rtl/outmode_regs.sv
module outmode_regs #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned NCH    = 2,
    parameter int unsigned CTL_W  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_we,
    input  logic [CTL_W-1:0]        ctl_wdata,
    input  logic [NCH-1:0]          code_we,
    input  logic [CODE_W-1:0]       code_wdata,
    output logic [2*NCH-1:0]        ctl_o,
    output logic [NCH*CODE_W-1:0]   code_o
);
    localparam int unsigned MODE_BITS = 2 * NCH;

    typedef struct packed {
        logic [NCH*CODE_W-1:0] code;
        logic [MODE_BITS-1:0]  ctl;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            st_d.ctl = ctl_wdata[MODE_BITS-1:0];
        end
        for (int i = 0; i < NCH; i++) begin
            if (code_we[i]) begin
                st_d.code[i*CODE_W +: CODE_W] = code_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_o  = st_q.ctl;
    assign code_o = st_q.code;
endmodule

// File: rtl/outmode_chan.sv
module outmode_chan
    import outmode_pkg::*;
#(
    parameter int unsigned CODE_W = 8
) (
    input  logic [CODE_W-1:0] code_i,
    input  logic              pdn_i,
    input  logic              mute_i,
    output logic [CODE_W-1:0] code_o,
    output logic              low_o,
    output logic              hiz_o
);
    chan_mode_e mode;

    // Power-down outranks every mute source.
    always_comb begin
        if (pdn_i) begin
            mode = MODE_HIZ;
        end else if (mute_i) begin
            mode = MODE_LOW;
        end else begin
            mode = MODE_DRIVE;
        end
    end

    always_comb begin
        low_o  = (mode == MODE_LOW);
        hiz_o  = (mode == MODE_HIZ);
        code_o = (mode == MODE_DRIVE) ? code_i : '0;
    end
endmodule

// File: rtl/outmode_ctrl.sv
module outmode_ctrl
    import outmode_pkg::*;
#(
    parameter int unsigned CODE_W = CODE_W_DEF,
    parameter int unsigned NCH    = NCH_DEF,
    parameter int unsigned CTL_W  = CTL_W_DEF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  mute_n,
    input  logic                  pwrup_hold,
    input  logic                  ctl_we,
    input  logic [CTL_W-1:0]      ctl_wdata,
    input  logic [NCH-1:0]        code_we,
    input  logic [CODE_W-1:0]     code_wdata,
    output logic [CTL_W-1:0]      ctl_rdata,
    output logic [NCH*CODE_W-1:0] code_rdata,
    output logic [NCH*CODE_W-1:0] out_code,
    output logic [NCH-1:0]        out_low,
    output logic [NCH-1:0]        out_hiz
);
    localparam int unsigned MODE_BITS = 2 * NCH;

    logic [MODE_BITS-1:0]  ctl_q;
    logic [NCH*CODE_W-1:0] code_q;
    logic                  sync_hold;
    logic                  global_mute;

    outmode_regs #(
        .CODE_W (CODE_W),
        .NCH    (NCH),
        .CTL_W  (CTL_W)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .code_we    (code_we),
        .code_wdata (code_wdata),
        .ctl_o      (ctl_q),
        .code_o     (code_q)
    );

    outmode_mute_sync sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mute_n (mute_n),
        .hold_o (sync_hold)
    );

    assign global_mute = !mute_n || sync_hold || pwrup_hold;

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        outmode_chan #(
            .CODE_W (CODE_W)
        ) chan_i (
            .code_i (code_q[i*CODE_W +: CODE_W]),
            .pdn_i  (ctl_q[i]),
            .mute_i (ctl_q[NCH+i] || global_mute),
            .code_o (out_code[i*CODE_W +: CODE_W]),
            .low_o  (out_low[i]),
            .hiz_o  (out_hiz[i])
        );
    end

    assign ctl_rdata  = {{(CTL_W-MODE_BITS){1'b0}}, ctl_q};
    assign code_rdata = code_q;
endmodule

// File: rtl/outmode_ctrl_chk.sv
module outmode_ctrl_chk #(
    parameter int unsigned CODE_W = 8,
    parameter int unsigned NCH    = 2,
    parameter int unsigned CTL_W  = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  mute_n,
    input logic                  pwrup_hold,
    input logic                  ctl_we,
    input logic [CTL_W-1:0]      ctl_wdata,
    input logic [NCH-1:0]        code_we,
    input logic [CODE_W-1:0]     code_wdata,
    input logic [CTL_W-1:0]      ctl_rdata,
    input logic [NCH*CODE_W-1:0] code_rdata,
    input logic [NCH*CODE_W-1:0] out_code,
    input logic [NCH-1:0]        out_low,
    input logic [NCH-1:0]        out_hiz
);
    localparam int unsigned MODE_BITS = 2 * NCH;

    assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_rdata[CTL_W-1:MODE_BITS] == '0);

    assert_ctl_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> $stable(ctl_rdata));

    for (genvar i = 0; i < NCH; i++) begin : g_chk
        assert_code_kept_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !code_we[i] |=> $stable(code_rdata[i*CODE_W +: CODE_W]));

        assert_pd_hiz_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_rdata[i] |-> (out_hiz[i] && !out_low[i]
                              && out_code[i*CODE_W +: CODE_W] == '0));

        assert_mute_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_rdata[NCH+i] && !ctl_rdata[i]) |->
                (out_low[i] && out_code[i*CODE_W +: CODE_W] == '0));

        assert_pin_mute_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!mute_n && !ctl_rdata[i]) |-> out_low[i]);

        assert_hold_mute_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (pwrup_hold && !ctl_rdata[i]) |-> out_low[i]);

        assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(mute_n) && !ctl_rdata[i] && !ctl_we) |=> out_low[i]);
    end
endmodule

bind outmode_ctrl outmode_ctrl_chk #(
    .CODE_W (CODE_W),
    .NCH    (NCH),
    .CTL_W  (CTL_W)
) chk_i (.*);

// File: tb/outmode_ctrl_tb_top.sv
`timescale 1ns/1ps
module outmode_ctrl_tb_top;
    localparam int NV = 12;

    typedef struct packed {
        logic        cwe;
        logic [7:0]  cwd;
        logic [1:0]  dwe;
        logic [7:0]  dwd;
        logic        hold;
        logic [15:0] e_code;
        logic [1:0]  e_low;
        logic [1:0]  e_hiz;
        logic [7:0]  e_ctl;
    } vec_t;

    // ch1 code in [15:8], ch0 in [7:0]; mode bits: 0 pd0, 1 pd1, 2 mute0, 3 mute1
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 2'b01, 8'h5A, 1'b0, 16'h005A, 2'b00, 2'b00, 8'h00}, // R2 ch0
        '{1'b0, 8'h00, 2'b10, 8'hC3, 1'b0, 16'hC35A, 2'b00, 2'b00, 8'h00}, // R2 ch1
        '{1'b1, 8'hF4, 2'b00, 8'h00, 1'b0, 16'hC300, 2'b01, 2'b00, 8'h04}, // R3 R4
        '{1'b0, 8'h00, 2'b01, 8'h11, 1'b0, 16'hC300, 2'b01, 2'b00, 8'h04}, // R10 write while muted
        '{1'b1, 8'h00, 2'b00, 8'h00, 1'b0, 16'hC311, 2'b00, 2'b00, 8'h00}, // R10 released
        '{1'b1, 8'h02, 2'b00, 8'h00, 1'b0, 16'h0011, 2'b00, 2'b10, 8'h02}, // R5 pd ch1
        '{1'b1, 8'h0A, 2'b00, 8'h00, 1'b0, 16'h0011, 2'b00, 2'b10, 8'h0A}, // R6 ch1
        '{1'b1, 8'h05, 2'b00, 8'h00, 1'b0, 16'hC300, 2'b00, 2'b01, 8'h05}, // R6 ch0
        '{1'b0, 8'h00, 2'b00, 8'h00, 1'b1, 16'h0000, 2'b10, 2'b01, 8'h05}, // R9
        '{1'b1, 8'h08, 2'b00, 8'h00, 1'b0, 16'h0011, 2'b10, 2'b00, 8'h08}, // R4 ch1
        '{1'b0, 8'h00, 2'b11, 8'hFF, 1'b0, 16'h00FF, 2'b10, 2'b00, 8'h08}, // R2 both, R10
        '{1'b1, 8'h00, 2'b00, 8'h00, 1'b0, 16'hFFFF, 2'b00, 2'b00, 8'h00}  // R10 released
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mute_n = 1'b1;
    logic        pwrup_hold = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic [1:0]  code_we = '0;
    logic [7:0]  code_wdata = '0;
    logic [7:0]  ctl_rdata;
    logic [15:0] code_rdata;
    logic [15:0] out_code;
    logic [1:0]  out_low;
    logic [1:0]  out_hiz;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    outmode_ctrl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mute_n     (mute_n),
        .pwrup_hold (pwrup_hold),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .code_we    (code_we),
        .code_wdata (code_wdata),
        .ctl_rdata  (ctl_rdata),
        .code_rdata (code_rdata),
        .out_code   (out_code),
        .out_low    (out_low),
        .out_hiz    (out_hiz)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 low", {30'd0, out_low}, 32'h3);
        check("R1 hiz", {30'd0, out_hiz}, 32'h0);
        check("R1 code", {16'd0, out_code}, 32'h0);
        check("R1 ctl", {24'd0, ctl_rdata}, 32'h0);
        check("R1 stored", {16'd0, code_rdata}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 low after 1st edge", {30'd0, out_low}, 32'h3);
        @(negedge clk);
        check("R1 low after 2nd edge", {30'd0, out_low}, 32'h0);

        // table walk
        for (int k = 0; k < NV; k++) begin
            ctl_we     = VECS[k].cwe;
            ctl_wdata  = VECS[k].cwd;
            code_we    = VECS[k].dwe;
            code_wdata = VECS[k].dwd;
            pwrup_hold = VECS[k].hold;
            @(negedge clk);
            ctl_we  = 1'b0;
            code_we = '0;
            check($sformatf("R2-table v%0d code", k), {16'd0, out_code}, {16'd0, VECS[k].e_code});
            check($sformatf("R4 R5 v%0d low", k), {30'd0, out_low}, {30'd0, VECS[k].e_low});
            check($sformatf("R5 R6 v%0d hiz", k), {30'd0, out_hiz}, {30'd0, VECS[k].e_hiz});
            check($sformatf("R3 v%0d ctl", k), {24'd0, ctl_rdata}, {24'd0, VECS[k].e_ctl});
        end
        pwrup_hold = 1'b0;
        check("R11 codes after mode writes", {16'd0, code_rdata}, 32'h0000FFFF);

        // R7: pin mute acts without a clock edge
        @(posedge clk);
        #1;
        mute_n = 1'b0;
        #0.5;
        check("R7 low", {30'd0, out_low}, 32'h3);
        check("R7 code", {16'd0, out_code}, 32'h0);
        check("R4 stored kept under mute", {16'd0, code_rdata}, 32'h0000FFFF);

        // R8: release takes two edges
        @(negedge clk);
        mute_n = 1'b1;
        @(negedge clk);
        check("R8 still muted after 1st edge", {30'd0, out_low}, 32'h3);
        @(negedge clk);
        check("R8 released after 2nd edge", {30'd0, out_low}, 32'h0);
        check("R8 code restored", {16'd0, out_code}, 32'h0000FFFF);

        // R11: code write leaves mode register alone
        ctl_wdata = 8'h0C;
        ctl_we = 1'b1;
        @(negedge clk);
        ctl_we = 1'b0;
        code_wdata = 8'h3C;
        code_we = 2'b01;
        @(negedge clk);
        code_we = '0;
        check("R11 ctl after code write", {24'd0, ctl_rdata}, 32'h0C);
        check("R10 stored while muted", {16'd0, code_rdata}, 32'h0000FF3C);
        check("R4 both muted", {30'd0, out_low}, 32'h3);

        finish_run();
    end
endmodule